// File: doc/BRIEF.md
# Audio Output Mode Routing Controller

This block converts a 4-bit output mode code into control for two stereo output paths: a loudspeaker pair and a headphone pair. For each path it reports a power state (off, muted, or playing) and the source feeding it (mono only, left/right stereo, or stereo summed with mono). It also gates a per-path surround-effect enable. When a path comes out of shutdown, it is held muted for a wake-up delay before it starts playing. The delay is fast or slow, and a configuration bit picks which one.

The configuration inputs are register outputs. The block samples them on every clock. A reserved mode code is ignored, so the last valid mode stays in force. The two wake-up delays are parameters given in clock cycles. The analog signal chain is controlled elsewhere from these outputs.

Top module: `audio_route_ctrl`

## Requirements
- R1: After reset, both paths are off (power code 0), both sources are none (source code 0), and both effect outputs and both ready flags are low.
- R2: A valid mode code takes effect on the clock edge after it is presented. Codes 2, 7 and 12 request the speakers playing and the headphones muted. Codes 3, 8 and 13 request both paths playing. Codes 4, 9 and 14 request the speakers off and the headphones playing. Power codes are 0 = off, 1 = muted, 2 = playing.
- R3: The source code of a powered path is 1 (mono) for modes 2–4, 2 (stereo) for modes 7–9, and 3 (stereo plus mono) for modes 12–14. The source code of an off path is 0.
- R4: Codes 1, 5, 6, 10, 11 and 15 are reserved and have no effect: every output keeps its previous value.
- R5: Code 0 turns both paths off on the next clock.
- R6: A path that goes from off to powered shows power code 1 with ready low for exactly FAST_WAKE_CYCLES clocks when the wake select is 0, or SLOW_WAKE_CYCLES clocks when it is 1. After that it shows its requested state with ready high.
- R7: A path that is already powered and awake switches between muted and playing on the next clock, with no new wake-up delay.
- R8: A path that is turned off drops to power code 0 with ready low on the next clock. A later power-up runs the full wake-up delay again.
- R9: The effect output of each path is high exactly when that path's effect enable input (registered) is high and the path's power code is 2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgMode | input | 4 | Output mode code |
| cfgSlowWake | input | 1 | Wake-up select: 0 fast, 1 slow |
| cfgSpkFx | input | 1 | Surround enable for the loudspeaker pair |
| cfgHpFx | input | 1 | Surround enable for the headphone pair |
| spkPower | output | 2 | Loudspeaker power code (0 off, 1 muted, 2 playing) |
| hpPower | output | 2 | Headphone power code |
| spkSource | output | 2 | Loudspeaker source (0 none, 1 mono, 2 stereo, 3 mix) |
| hpSource | output | 2 | Headphone source |
| spkFx | output | 1 | Surround active on loudspeakers |
| hpFx | output | 1 | Surround active on headphones |
| spkReady | output | 1 | Loudspeaker path powered and settled |
| hpReady | output | 1 | Headphone path powered and settled |

## Verification
The hardest situations to reach are a path that stays powered while the mode changes around it, and a path that is restarted after shutdown. The stimulus first wakes a path fully. It then moves to another mode that keeps that path powered and checks that no fresh delay appears. Later it turns the path off and powers it up again, and checks that the full delay is counted once more. The slow setting is exercised on the loudspeakers while the headphones are already awake, so both kinds of behaviour are visible in the same window.

// File: rtl/audio_route_pkg.sv
package audio_route_pkg;

  localparam int NUM_PATHS = 2;
  localparam int PATH_SPK  = 0;
  localparam int PATH_HP   = 1;

  typedef enum logic [1:0] {
    PWR_OFF  = 2'd0,
    PWR_MUTE = 2'd1,
    PWR_ON   = 2'd2
  } pwr_e;

  typedef enum logic [1:0] {
    SRC_NONE   = 2'd0,
    SRC_MONO   = 2'd1,
    SRC_STEREO = 2'd2,
    SRC_MIX    = 2'd3
  } src_e;

  // strobes from control to the wake datapath, one bit per path
  typedef struct packed {
    logic [NUM_PATHS-1:0] powerReq;
    logic [NUM_PATHS-1:0] activeReq;
    logic [NUM_PATHS-1:0] fxEn;
    logic                 slowSel;
  } wake_ctl_t;

  function automatic logic modeIsValid(input logic [3:0] m);
    return !(m inside {4'd1, 4'd5, 4'd6, 4'd10, 4'd11, 4'd15});
  endfunction

endpackage

// File: rtl/audio_route_ctl.sv
module audio_route_ctl
  import audio_route_pkg::*;
#(
  parameter int MODE_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [MODE_W-1:0] cfgMode,
  input  logic              cfgSlowWake,
  input  logic              cfgSpkFx,
  input  logic              cfgHpFx,
  output wake_ctl_t         ctl,
  output logic [1:0]        spkSource,
  output logic [1:0]        hpSource
);

  logic [MODE_W-1:0] modeQ;
  logic              slowQ;
  logic [NUM_PATHS-1:0] fxQ;
  src_e grp;
  pwr_e spkReq, hpReq;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeQ <= '0;
      slowQ <= 1'b0;
      fxQ   <= '0;
    end else begin
      if (modeIsValid(4'(cfgMode))) modeQ <= cfgMode;
      slowQ <= cfgSlowWake;
      fxQ   <= {cfgHpFx, cfgSpkFx};
    end
  end

  always_comb begin
    grp = SRC_NONE;
    case (4'(modeQ))
      4'd2, 4'd3, 4'd4:    grp = SRC_MONO;
      4'd7, 4'd8, 4'd9:    grp = SRC_STEREO;
      4'd12, 4'd13, 4'd14: grp = SRC_MIX;
      default:             grp = SRC_NONE;
    endcase
  end

  always_comb begin
    spkReq = PWR_OFF;
    hpReq  = PWR_OFF;
    case (4'(modeQ))
      4'd2, 4'd7, 4'd12: begin spkReq = PWR_ON;  hpReq = PWR_MUTE; end
      4'd3, 4'd8, 4'd13: begin spkReq = PWR_ON;  hpReq = PWR_ON;   end
      4'd4, 4'd9, 4'd14: begin spkReq = PWR_OFF; hpReq = PWR_ON;   end
      default:           begin spkReq = PWR_OFF; hpReq = PWR_OFF;  end
    endcase
  end

  always_comb begin
    ctl.powerReq[PATH_SPK]  = (spkReq != PWR_OFF);
    ctl.powerReq[PATH_HP]   = (hpReq != PWR_OFF);
    ctl.activeReq[PATH_SPK] = (spkReq == PWR_ON);
    ctl.activeReq[PATH_HP]  = (hpReq == PWR_ON);
    ctl.fxEn                = fxQ;
    ctl.slowSel             = slowQ;
  end

  assign spkSource = ctl.powerReq[PATH_SPK] ? grp : SRC_NONE;
  assign hpSource  = ctl.powerReq[PATH_HP]  ? grp : SRC_NONE;

endmodule

// File: rtl/audio_route_wake.sv
module audio_route_wake
  import audio_route_pkg::*;
#(
  parameter int FAST_WAKE_CYCLES = 3000000,
  parameter int SLOW_WAKE_CYCLES = 7000000
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  wake_ctl_t                      ctl,
  output logic [NUM_PATHS-1:0][1:0]      pathPower,
  output logic [NUM_PATHS-1:0]           pathReady,
  output logic [NUM_PATHS-1:0]           pathFx
);

  localparam int MAX_CYCLES = (SLOW_WAKE_CYCLES > FAST_WAKE_CYCLES) ?
                              SLOW_WAKE_CYCLES : FAST_WAKE_CYCLES;
  localparam int CNT_W = $clog2(MAX_CYCLES + 1);
  localparam logic [CNT_W-1:0] FAST_LAST = CNT_W'(FAST_WAKE_CYCLES - 1);
  localparam logic [CNT_W-1:0] SLOW_LAST = CNT_W'(SLOW_WAKE_CYCLES - 1);

  logic [CNT_W-1:0] lastTick;
  assign lastTick = ctl.slowSel ? SLOW_LAST : FAST_LAST;

  for (genvar i = 0; i < NUM_PATHS; i++) begin : g_path
    logic [CNT_W-1:0] cnt;
    logic             awake;

    always_ff @(posedge clk) begin
      if (!rstN) begin
        cnt   <= '0;
        awake <= 1'b0;
      end else if (!ctl.powerReq[i]) begin
        cnt   <= '0;
        awake <= 1'b0;
      end else if (!awake) begin
        if (cnt >= lastTick) awake <= 1'b1;
        else                 cnt   <= cnt + 1'b1;
      end
    end

    always_comb begin
      if (!ctl.powerReq[i])                pathPower[i] = PWR_OFF;
      else if (!awake || !ctl.activeReq[i]) pathPower[i] = PWR_MUTE;
      else                                  pathPower[i] = PWR_ON;
    end

    assign pathReady[i] = ctl.powerReq[i] && awake;
    assign pathFx[i]    = ctl.fxEn[i] && (pathPower[i] == PWR_ON);
  end

endmodule

// File: rtl/audio_route_ctrl.sv
module audio_route_ctrl
  import audio_route_pkg::*;
#(
  parameter int FAST_WAKE_CYCLES = 3000000,
  parameter int SLOW_WAKE_CYCLES = 7000000
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [3:0] cfgMode,
  input  logic       cfgSlowWake,
  input  logic       cfgSpkFx,
  input  logic       cfgHpFx,
  output logic [1:0] spkPower,
  output logic [1:0] hpPower,
  output logic [1:0] spkSource,
  output logic [1:0] hpSource,
  output logic       spkFx,
  output logic       hpFx,
  output logic       spkReady,
  output logic       hpReady
);

  wake_ctl_t                      ctl;
  logic [NUM_PATHS-1:0][1:0]      pathPower;
  logic [NUM_PATHS-1:0]           pathReady;
  logic [NUM_PATHS-1:0]           pathFx;

  audio_route_ctl #(.MODE_W(4)) u_ctl (
    .clk(clk), .rstN(rstN), .cfgMode(cfgMode), .cfgSlowWake(cfgSlowWake),
    .cfgSpkFx(cfgSpkFx), .cfgHpFx(cfgHpFx), .ctl(ctl),
    .spkSource(spkSource), .hpSource(hpSource)
  );

  audio_route_wake #(
    .FAST_WAKE_CYCLES(FAST_WAKE_CYCLES),
    .SLOW_WAKE_CYCLES(SLOW_WAKE_CYCLES)
  ) u_wake (
    .clk(clk), .rstN(rstN), .ctl(ctl),
    .pathPower(pathPower), .pathReady(pathReady), .pathFx(pathFx)
  );

  assign spkPower = pathPower[PATH_SPK];
  assign hpPower  = pathPower[PATH_HP];
  assign spkReady = pathReady[PATH_SPK];
  assign hpReady  = pathReady[PATH_HP];
  assign spkFx    = pathFx[PATH_SPK];
  assign hpFx     = pathFx[PATH_HP];

endmodule

// File: rtl/audio_route_chk.sv
module audio_route_chk (
  input logic       clk,
  input logic       rstN,
  input logic [3:0] cfgMode,
  input logic [1:0] spkPower,
  input logic [1:0] hpPower,
  input logic [1:0] spkSource,
  input logic [1:0] hpSource,
  input logic       spkFx,
  input logic       hpFx,
  input logic       spkReady,
  input logic       hpReady
);

  a_r5_zero_turns_off: assert property (@(posedge clk) disable iff (!rstN)
    (cfgMode == 4'd0) |=> (spkPower == 2'd0 && hpPower == 2'd0));

  a_r4_reserved_holds_source: assert property (@(posedge clk) disable iff (!rstN)
    (cfgMode inside {4'd1, 4'd5, 4'd6, 4'd10, 4'd11, 4'd15})
      |=> ($stable(spkSource) && $stable(hpSource)));

  a_r6_spk_wake_starts_muted: assert property (@(posedge clk) disable iff (!rstN)
    (spkPower != 2'd0 && $past(spkPower) == 2'd0) |-> (spkPower == 2'd1 && !spkReady));

  a_r6_hp_wake_starts_muted: assert property (@(posedge clk) disable iff (!rstN)
    (hpPower != 2'd0 && $past(hpPower) == 2'd0) |-> (hpPower == 2'd1 && !hpReady));

  a_r8_spk_off_not_ready: assert property (@(posedge clk) disable iff (!rstN)
    (spkPower == 2'd0) |-> (!spkReady && spkSource == 2'd0));

  a_r8_hp_off_not_ready: assert property (@(posedge clk) disable iff (!rstN)
    (hpPower == 2'd0) |-> (!hpReady && hpSource == 2'd0));

  a_r9_spk_fx_when_playing: assert property (@(posedge clk) disable iff (!rstN)
    spkFx |-> (spkPower == 2'd2 && spkReady));

  a_r9_hp_fx_when_playing: assert property (@(posedge clk) disable iff (!rstN)
    hpFx |-> (hpPower == 2'd2 && hpReady));

endmodule

bind audio_route_ctrl audio_route_chk u_chk (
  .clk(clk), .rstN(rstN), .cfgMode(cfgMode),
  .spkPower(spkPower), .hpPower(hpPower),
  .spkSource(spkSource), .hpSource(hpSource),
  .spkFx(spkFx), .hpFx(hpFx), .spkReady(spkReady), .hpReady(hpReady)
);

// File: tb/audio_route_ctrl_tb.sv
module audio_route_ctrl_tb;

  localparam int FAST = 6;
  localparam int SLOW = 14;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [3:0] cfgMode = 4'd0;
  logic cfgSlowWake = 1'b0;
  logic cfgSpkFx = 1'b0;
  logic cfgHpFx = 1'b0;
  logic [1:0] spkPower, hpPower, spkSource, hpSource;
  logic spkFx, hpFx, spkReady, hpReady;

  int cyc = 0;
  int base = 0;
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  typedef struct {
    int          at;
    logic [11:0] vec;
    string       tag;
  } item_t;
  item_t sbQ[$];

  always #5 clk = ~clk;

  audio_route_ctrl #(.FAST_WAKE_CYCLES(FAST), .SLOW_WAKE_CYCLES(SLOW)) u_dut (
    .clk(clk), .rstN(rstN), .cfgMode(cfgMode), .cfgSlowWake(cfgSlowWake),
    .cfgSpkFx(cfgSpkFx), .cfgHpFx(cfgHpFx),
    .spkPower(spkPower), .hpPower(hpPower),
    .spkSource(spkSource), .hpSource(hpSource),
    .spkFx(spkFx), .hpFx(hpFx), .spkReady(spkReady), .hpReady(hpReady)
  );

  always @(posedge clk) cyc <= cyc + 1;

  // expected outputs {spkPower, hpPower, spkSource, hpSource, spkFx, hpFx, spkReady, hpReady}
  function automatic logic [11:0] expVec(int m, bit spkAwake, bit hpAwake, bit fs, bit fh);
    int grp, pat;
    logic [1:0] sReq, hReq, sp, hp, ss, hs;
    bit sf, hf, sr, hr;
    if (m >= 2 && m <= 4) grp = 1;
    else if (m >= 7 && m <= 9) grp = 2;
    else if (m >= 12 && m <= 14) grp = 3;
    else grp = 0;
    pat = (grp != 0) ? (m - 2) % 5 : -1;
    sReq = (pat == 0 || pat == 1) ? 2'd2 : 2'd0;
    hReq = (pat == 0) ? 2'd1 : ((pat == 1 || pat == 2) ? 2'd2 : 2'd0);
    sp = (sReq == 2'd0) ? 2'd0 : (spkAwake ? sReq : 2'd1);
    hp = (hReq == 2'd0) ? 2'd0 : (hpAwake ? hReq : 2'd1);
    ss = (sReq == 2'd0) ? 2'd0 : 2'(grp);
    hs = (hReq == 2'd0) ? 2'd0 : 2'(grp);
    sr = (sReq != 2'd0) && spkAwake;
    hr = (hReq != 2'd0) && hpAwake;
    sf = fs && (sp == 2'd2);
    hf = fh && (hp == 2'd2);
    return {sp, hp, ss, hs, sf, hf, sr, hr};
  endfunction

  // monitor: pop and compare when the scheduled cycle arrives
  always @(negedge clk) begin
    while (sbQ.size() > 0 && sbQ[0].at == cyc) begin
      item_t it;
      logic [11:0] got;
      it = sbQ.pop_front();
      got = {spkPower, hpPower, spkSource, hpSource, spkFx, hpFx, spkReady, hpReady};
      checks++;
      if (got !== it.vec) begin
        fails++;
        $display("FAIL %s cycle %0d: got %h expected %h", it.tag, cyc, got, it.vec);
      end
    end
  end

  task automatic drive(int m, bit slow, bit fs, bit fh);
    @(negedge clk);
    cfgMode = 4'(m);
    cfgSlowWake = slow;
    cfgSpkFx = fs;
    cfgHpFx = fh;
    base = cyc;
  endtask

  task automatic expectAt(int off, logic [11:0] v, string tag);
    item_t it;
    it.at = base + off;
    it.vec = v;
    it.tag = tag;
    sbQ.push_back(it);
  endtask

  task automatic waitCyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    waitCyc(3);
    rstN = 1'b1;
    base = cyc;
    expectAt(1, 12'h000, "R1 reset state");
    waitCyc(1);

    // R2 R3 R6: both paths wake with fast delay, mono source
    drive(3, 1'b0, 1'b1, 1'b1);
    expectAt(1, expVec(3, 0, 0, 1, 1), "R6 wake start muted");
    expectAt(FAST, expVec(3, 0, 0, 1, 1), "R6 still muted at fast limit");
    expectAt(FAST + 1, expVec(3, 1, 1, 1, 1), "R2 R9 both playing after fast wake");
    waitCyc(FAST + 1);

    // R7: stereo, already awake, no new delay
    drive(8, 1'b0, 1'b0, 1'b1);
    expectAt(1, expVec(8, 1, 1, 0, 1), "R7 R3 stereo no re-wake");
    waitCyc(1);

    drive(7, 1'b0, 1'b0, 1'b1);
    expectAt(1, expVec(7, 1, 1, 0, 1), "R7 headphone muted next clock");
    waitCyc(1);

    // R4: reserved code ignored
    drive(5, 1'b0, 1'b0, 1'b1);
    expectAt(1, expVec(7, 1, 1, 0, 1), "R4 code 5 ignored");
    expectAt(2, expVec(7, 1, 1, 0, 1), "R4 code 5 still ignored");
    waitCyc(2);

    // R8: speakers off at once
    drive(9, 1'b0, 1'b0, 1'b1);
    expectAt(1, expVec(9, 0, 1, 0, 1), "R8 speaker off next clock");
    waitCyc(1);

    // R6 slow wake on speakers while headphones stay awake, R3 mix
    drive(12, 1'b1, 1'b1, 1'b0);
    expectAt(1, expVec(12, 0, 1, 1, 0), "R6 R3 slow wake start");
    expectAt(SLOW, expVec(12, 0, 1, 1, 0), "R6 muted at slow limit");
    expectAt(SLOW + 1, expVec(12, 1, 1, 1, 0), "R6 R9 speaker plays after slow wake");
    waitCyc(SLOW + 1);

    drive(13, 1'b0, 1'b1, 1'b1);
    expectAt(1, expVec(13, 1, 1, 1, 1), "R7 R3 mix both playing");
    waitCyc(1);

    // R5 then R4 with code 15 and code 1
    drive(0, 1'b0, 1'b1, 1'b1);
    expectAt(1, 12'h000, "R5 code 0 all off");
    waitCyc(1);
    drive(15, 1'b0, 1'b1, 1'b1);
    expectAt(1, 12'h000, "R4 code 15 ignored");
    waitCyc(1);
    drive(1, 1'b0, 1'b1, 1'b1);
    expectAt(1, 12'h000, "R4 code 1 ignored");
    waitCyc(1);

    // headphones only, fast
    drive(4, 1'b0, 1'b1, 1'b1);
    expectAt(1, expVec(4, 0, 0, 1, 1), "R2 headphone wake start");
    expectAt(FAST + 1, expVec(4, 0, 1, 1, 1), "R6 headphone ready");
    waitCyc(FAST + 1);

    // R8: off then on again restarts full delay
    drive(0, 1'b0, 1'b1, 1'b1);
    expectAt(1, 12'h000, "R8 off drops ready");
    waitCyc(1);
    drive(14, 1'b0, 1'b1, 1'b1);
    expectAt(1, expVec(14, 0, 0, 1, 1), "R8 restart muted");
    expectAt(FAST, expVec(14, 0, 0, 1, 1), "R8 restart still muted");
    expectAt(FAST + 1, expVec(14, 0, 1, 1, 1), "R8 restart ready after full delay");
    waitCyc(FAST + 3);

    if (sbQ.size() != 0) begin
      fails++;
      $display("FAIL R1 scoreboard left %0d items, expected 0", sbQ.size());
    end
    done = 1'b1;
    report();
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: run did not finish, got timeout expected completion");
      report();
    end
  end

endmodule